// File: doc/BRIEF.md
# Four-Way Age-Counter Replacement Tracker

This block keeps the replacement state of a single four-way set in a set-associative cache. Each way holds an occupancy flag and a small age counter, where age 0 marks the most recently used way and the largest age marks the least recently used one. The cache's tag logic tells the block, once per access, whether the access hit (and in which way) or missed. The block then updates the ages on the next clock edge.

On a miss the block names the way to fill. This is the lowest-numbered empty way when one exists. Otherwise it is the way whose age is at the maximum. The fill choice is combinational from the stored state, so the cache controller can use it in the same cycle it detects the miss. A synchronous flush empties the whole set in one cycle.

Top module: `lru4_age_tracker`

## Requirements
- R1: After reset, and one cycle after `flush` is sampled high, every valid bit and every age counter is 0. `flush` takes priority over a simultaneous access.
- R2: On a hit to a valid way, that way's age becomes 0. Every other valid way whose age was below the hit way's old age gains one. All other ages are unchanged.
- R3: On a miss while at least one way is empty, `fill_way` is the lowest-numbered empty way. That way becomes valid with age 0, and each other valid way's age gains one.
- R4: On a miss while all ways are valid, `fill_way` is the way whose age is 3 (the all-ones value). That way takes age 0, and each of the other ways gains one.
- R5: The ages of the valid ways are always pairwise distinct.
- R6: A hit reported on an empty way changes neither the valid bits nor the ages.
- R7: `fill_way` is a combinational function of the present state. It follows a state change in the same cycle that state appears on `way_valid` and `way_age`.
- R8: In a cycle without `acc_valid` and without `flush`, the state is unchanged.
- R9: Way i's age is presented on `way_age[2*i+1:2*i]`, and its valid bit on `way_valid[i]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Empty the set on the next edge |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_hit | input | 1 | 1 = the access hit, 0 = the access missed |
| hit_way | input | 2 | Way that hit (used only when `acc_hit` is 1) |
| fill_way | output | 2 | Way to fill on a miss |
| way_valid | output | 4 | Valid bit per way |
| way_age | output | 8 | Age counter per way, 2 bits each |

## Verification
The assertions assume three things about the inputs: one access per cycle at most, no X values on `hit_way` while `acc_valid` is high, and no second fill of the same line before the tag logic reports it. This block does not look at tags, so the last of these is the caller's concern. The stimulus mixes hits on random ways, including empty ones, with misses and rare flushes. Every input combination it produces is therefore legal for the block, and the hits on empty ways exercise the ignore rule. The full-set eviction rule is expected to hold only because the ages stay distinct. Long runs of misses into a full set keep that invariant under steady pressure.

// File: rtl/lru4_pkg.sv
package lru4_pkg;
  typedef enum logic [1:0] {
    UPD_NONE  = 2'd0,
    UPD_TOUCH = 2'd1,
    UPD_FILL  = 2'd2,
    UPD_EVICT = 2'd3
  } upd_kind_e;
endpackage

// File: rtl/lru4_fill_pick.sv
module lru4_fill_pick #(
  parameter int NWAY = 4,
  parameter int AW   = 2,
  localparam int IW  = (NWAY > 1) ? $clog2(NWAY) : 1
) (
  input  logic [NWAY-1:0]         valid,
  input  logic [NWAY-1:0][AW-1:0] ages,
  output logic [IW-1:0]           pick,
  output logic                    all_full
);
  localparam logic [AW-1:0] OLDEST = '1;

  always_comb begin
    all_full = &valid;
    pick = '0;
    for (int i = NWAY - 1; i >= 0; i--) begin
      if (all_full) begin
        if (ages[i] == OLDEST) pick = IW'(i);
      end else if (!valid[i]) begin
        pick = IW'(i);
      end
    end
  end
endmodule

// File: rtl/lru4_age_next.sv
module lru4_age_next
  import lru4_pkg::*;
#(
  parameter int NWAY = 4,
  parameter int AW   = 2,
  localparam int IW  = (NWAY > 1) ? $clog2(NWAY) : 1
) (
  input  upd_kind_e               kind,
  input  logic [IW-1:0]           target,
  input  logic [NWAY-1:0]         valid,
  input  logic [NWAY-1:0][AW-1:0] ages,
  output logic [NWAY-1:0]         valid_nxt,
  output logic [NWAY-1:0][AW-1:0] ages_nxt
);
  logic [AW-1:0] ref_age;
  assign ref_age = ages[target];

  for (genvar g = 0; g < NWAY; g++) begin : g_way
    logic is_tgt;
    assign is_tgt = (target == IW'(g));
    always_comb begin
      valid_nxt[g] = valid[g];
      ages_nxt[g]  = ages[g];
      unique case (kind)
        UPD_TOUCH: begin
          if (is_tgt) ages_nxt[g] = '0;
          else if (valid[g] && ages[g] < ref_age) ages_nxt[g] = ages[g] + 1'b1;
        end
        UPD_FILL, UPD_EVICT: begin
          if (is_tgt) begin
            ages_nxt[g]  = '0;
            valid_nxt[g] = 1'b1;
          end else if (valid[g]) begin
            ages_nxt[g] = ages[g] + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/lru4_age_tracker.sv
module lru4_age_tracker
  import lru4_pkg::*;
#(
  parameter int NWAY = 4,
  localparam int AW  = (NWAY > 1) ? $clog2(NWAY) : 1,
  localparam int IW  = AW
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 flush,
  input  logic                 acc_valid,
  input  logic                 acc_hit,
  input  logic [IW-1:0]        hit_way,
  output logic [IW-1:0]        fill_way,
  output logic [NWAY-1:0]      way_valid,
  output logic [NWAY*AW-1:0]   way_age
);
  localparam logic [AW-1:0] OLDEST = '1;

  logic [NWAY-1:0]         valid_q, valid_d;
  logic [NWAY-1:0][AW-1:0] ages_q, ages_d;
  logic                    set_full;
  logic                    hit_ok;
  upd_kind_e               kind;
  logic [IW-1:0]           target;

  lru4_fill_pick #(.NWAY(NWAY), .AW(AW)) u_pick (
    .valid(valid_q), .ages(ages_q), .pick(fill_way), .all_full(set_full)
  );

  assign hit_ok = acc_valid && acc_hit && valid_q[hit_way];

  always_comb begin
    kind   = UPD_NONE;
    target = fill_way;
    if (hit_ok) begin
      kind   = UPD_TOUCH;
      target = hit_way;
    end else if (acc_valid && !acc_hit) begin
      kind = set_full ? UPD_EVICT : UPD_FILL;
    end
  end

  lru4_age_next #(.NWAY(NWAY), .AW(AW)) u_next (
    .kind(kind), .target(target), .valid(valid_q), .ages(ages_q),
    .valid_nxt(valid_d), .ages_nxt(ages_d)
  );

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      valid_q <= '0;
      ages_q  <= '0;
    end else begin
      valid_q <= valid_d;
      ages_q  <= ages_d;
    end
  end

  assign way_valid = valid_q;
  assign way_age   = ages_q;

  // Checker logic: any two valid ways sharing an age
  logic dup_seen;
  always_comb begin
    dup_seen = 1'b0;
    for (int a = 0; a < NWAY; a++)
      for (int b = a + 1; b < NWAY; b++)
        if (valid_q[a] && valid_q[b] && ages_q[a] == ages_q[b]) dup_seen = 1'b1;
  end

  p_flush_clear_r1: assert property (@(posedge clk) disable iff (rst)
    flush |=> (way_valid == '0 && way_age == '0));

  p_hit_youngest_r2: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_hit && way_valid[hit_way] && !flush) |=> ages_q[$past(hit_way)] == '0);

  p_fill_grows_r3: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_hit && !(&way_valid) && !flush)
      |=> $countones(way_valid) == $countones($past(way_valid)) + 1);

  p_evict_oldest_r4: assert property (@(posedge clk) disable iff (rst)
    (&way_valid) |-> ages_q[fill_way] == OLDEST);

  p_ages_distinct_r5: assert property (@(posedge clk) disable iff (rst)
    !dup_seen);

  p_empty_hit_ignored_r6: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_hit && !way_valid[hit_way] && !flush)
      |=> ($stable(way_valid) && $stable(way_age)));

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!acc_valid && !flush) |=> ($stable(way_valid) && $stable(way_age)));
endmodule

// File: tb/lru4_age_tracker_bench.sv
module lru4_age_tracker_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCYC = 4000;

  logic clk = 1'b0;
  logic rst, flush, acc_valid, acc_hit;
  logic [1:0] hit_way, fill_way;
  logic [3:0] way_valid;
  logic [7:0] way_age;

  int checks = 0;
  int fails  = 0;
  int m_age[4];
  bit m_val[4];
  string last_tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  lru4_age_tracker u_lru4_age_tracker (
    .clk(clk), .rst(rst), .flush(flush), .acc_valid(acc_valid),
    .acc_hit(acc_hit), .hit_way(hit_way), .fill_way(fill_way),
    .way_valid(way_valid), .way_age(way_age)
  );

  function automatic int model_fill();
    for (int i = 0; i < 4; i++) if (!m_val[i]) return i;
    for (int i = 0; i < 4; i++) if (m_age[i] == 3) return i;
    return 0;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    int ev = 0, ea = 0;
    bit dup = 0;
    for (int i = 0; i < 4; i++) begin
      ev |= int'(m_val[i]) << i;
      ea |= m_age[i] << (2 * i);
    end
    // R9 field positions, R7 same-cycle fill choice
    check(way_valid == 4'(ev), {last_tag, " valid R9"}, int'(way_valid), ev);
    check(way_age == 8'(ea), {last_tag, " age R9"}, int'(way_age), ea);
    check(int'(fill_way) == model_fill(), "R7 fill_way", int'(fill_way), model_fill());
    for (int a = 0; a < 4; a++)
      for (int b = a + 1; b < 4; b++)
        if (way_valid[a] && way_valid[b] && way_age[2*a +: 2] == way_age[2*b +: 2]) dup = 1;
    check(!dup, "R5 distinct ages", int'(way_age), ea);
  endtask

  task automatic step_model(input bit f, input bit v, input bit h, input int w);
    if (f) begin
      for (int i = 0; i < 4; i++) begin m_val[i] = 0; m_age[i] = 0; end
      last_tag = "R1";
    end else if (!v) begin
      last_tag = "R8";
    end else if (h) begin
      if (!m_val[w]) last_tag = "R6";
      else begin
        int old = m_age[w];
        for (int i = 0; i < 4; i++)
          if (i != w && m_val[i] && m_age[i] < old) m_age[i]++;
        m_age[w] = 0;
        last_tag = "R2";
      end
    end else begin
      int t = model_fill();
      bit full = m_val[0] && m_val[1] && m_val[2] && m_val[3];
      for (int i = 0; i < 4; i++) if (i != t && m_val[i]) m_age[i]++;
      m_age[t] = 0;
      m_val[t] = 1;
      last_tag = full ? "R4" : "R3";
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst = 1; flush = 0; acc_valid = 0; acc_hit = 0; hit_way = 0;
    for (int i = 0; i < 4; i++) begin m_val[i] = 0; m_age[i] = 0; end
    last_tag = "R1";
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    compare_all();  // R1 reset state
    for (int c = 0; c < NCYC; c++) begin
      bit f, v, h;
      int w;
      int hit_pct;
      hit_pct = (c < NCYC / 2) ? 30 : 70;
      f = ($urandom % 80) == 0;
      v = ($urandom % 4) != 0;
      h = ($urandom % 100) < hit_pct;
      w = $urandom % 4;
      if (c % 500 < 20) begin h = 0; v = 1; end  // miss bursts, full-set pressure (R4)
      flush = f; acc_valid = v; acc_hit = h; hit_way = 2'(w);
      step_model(f, v, h, w);
      @(negedge clk);
      compare_all();
    end
    flush = 0; acc_valid = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule